// File: doc/BRIEF.md
# Two-Slot Parameter Cache with Memory Spill

This block sits between a producer of parameter words and a consumer that must be fed without pauses. The block keeps up to two words in its own registers and serves them in arrival order. If the producer gets ahead, the block writes the extra words out to a shared external synchronous memory. When a register slot frees up, it reads those words back. The external memory is used as a circular queue. Its read and write pointers and its occupancy count live inside the block.

A priority arbiter outside the block grants the memory accesses, so each access can take any number of cycles. The controller therefore holds a read request and a write request on their own lines. A request stays up until a completion pulse arrives for it. A refill read and a spill write may be outstanding at the same time. They may complete in either order.

The producer sees a ready flag. The consumer sees a valid flag and returns an acknowledge. No word is dropped, and the output order is strict first-in first-out across the registers and the memory.

Top module: `param_spill_cache`

## Requirements
- R1: After reset, out_valid, mem_wr_req and mem_rd_req are 0, in_ready is 1, and both memory addresses are 0.
- R2: Words leave on out_data, one per cycle in which out_valid and out_ack are both 1, in exactly the order in which they were accepted (accepted means in_valid and in_ready are both 1 at a rising edge).
- R3: A word accepted while the memory holds no words, no read is outstanding and fewer than two slots are occupied goes into a slot. out_valid is 1 with that word at the head one cycle after the accepting edge.
- R4: A word accepted under any other condition (both slots full, or memory non-empty, or read outstanding) is spilled. From the next cycle, mem_wr_req is 1 with the word on mem_wr_data and the write pointer on mem_wr_addr. All three are held until a cycle in which mem_wr_done is 1.
- R5: in_ready is 0 in every cycle in which a spill write is outstanding.
- R6: While the memory holds words and no read is outstanding, a read is requested once a slot is free after that cycle. mem_rd_req is held with mem_rd_addr stable until mem_rd_done. The word on mem_rd_data in the done cycle fills a slot. No read is requested while both slots stay full.
- R7: A spill write and a refill read can be outstanding together, with both requests at 1. Each ends on its own done pulse, in either order.
- R8: Each address starts at 0 and advances by one, wrapping after DEPTH-1, on each completed access of its own kind.
- R9: While out_valid is 1 and out_ack is 0, out_valid and out_data hold. out_ack while out_valid is 0 has no effect.
- R10: in_ready is 0 while DEPTH words are held in memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | DW | Offered word |
| in_ready | output | 1 | Block can accept a word |
| out_valid | output | 1 | A word is at the head |
| out_data | output | DW | Head word |
| out_ack | input | 1 | Consumer takes the head word |
| mem_wr_req | output | 1 | Spill write request |
| mem_wr_addr | output | AW | Spill write address |
| mem_wr_data | output | DW | Spill write data |
| mem_wr_done | input | 1 | Write completed this cycle |
| mem_rd_req | output | 1 | Refill read request |
| mem_rd_addr | output | AW | Refill read address |
| mem_rd_done | input | 1 | Read completed this cycle, data valid |
| mem_rd_data | input | DW | Read data |

## Verification
A word taken straight into a slot shows on out_data one cycle after the accepting edge. A spilled word shows on the write request lines one cycle after its accepting edge. A refilled word enters a slot at the edge that samples mem_rd_done and is visible from the following cycle. The bench drives and samples only at falling edges, so every such check reads the outputs one full settle period after the edge that produced them. The bench's memory model answers after a set number of falling edges and checks the address at the moment it completes each access.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY      = 3'd0,
        ST_PART       = 3'd1,
        ST_FULL       = 3'd2,
        ST_READ       = 3'd3,
        ST_WRITE      = 3'd4,
        ST_WRITE_READ = 3'd5
    } cache_st_e;

endpackage

// File: rtl/psc_slots.sv
module psc_slots #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [1:0]    occ,
    output logic [DW-1:0] head_data
);

    typedef struct packed {
        logic [1:0][DW-1:0] slot;
        logic               head;
        logic               tail;
        logic [1:0]         occ;
    } slots_t;

    slots_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.slot[s_q.tail] = push_data;
            s_d.tail           = ~s_q.tail;
        end
        if (pop) begin
            s_d.head = ~s_q.head;
        end
        s_d.occ = s_q.occ + 2'(push) - 2'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign occ       = s_q.occ;
    assign head_data = s_q.slot[s_q.head];

endmodule

// File: rtl/psc_spill_ptrs.sv
module psc_spill_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  logic          rd_commit,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_commit) p_d.wp = (p_q.wp == LAST) ? '0 : p_q.wp + 1'b1;
        if (rd_commit) p_d.rp = (p_q.rp == LAST) ? '0 : p_q.rp + 1'b1;
        p_d.cnt = p_q.cnt + CW'(wr_commit) - CW'(rd_commit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign wr_addr = p_q.wp;
    assign rd_addr = p_q.rp;
    assign count   = p_q.cnt;

endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
    import psc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          out_ack,
    input  logic [1:0]    occ,
    input  logic [CW-1:0] mem_count,
    input  logic          mem_wr_done,
    input  logic          mem_rd_done,
    input  logic [DW-1:0] mem_rd_data,
    output logic          slot_push,
    output logic [DW-1:0] slot_push_data,
    output logic          slot_pop,
    output logic          mem_wr_req,
    output logic [DW-1:0] mem_wr_data,
    output logic          mem_rd_req,
    output logic          wr_commit,
    output logic          rd_commit
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        cache_st_e     st;
        logic [DW-1:0] wdata;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic       wr_pend, rd_pend;
    logic       accept, direct, spill;
    logic       wr_fin, rd_fin;
    logic       wr_pend_n, rd_pend_n;
    logic [1:0] occ_n;

    assign wr_pend = (c_q.st == ST_WRITE) || (c_q.st == ST_WRITE_READ);
    assign rd_pend = (c_q.st == ST_READ)  || (c_q.st == ST_WRITE_READ);

    assign in_ready = !wr_pend && (mem_count < DEPTH_C);
    assign accept   = in_valid && in_ready;
    assign direct   = accept && !rd_pend && (mem_count == '0) && (occ != 2'd2);
    assign spill    = accept && !direct;
    assign wr_fin   = wr_pend && mem_wr_done;
    assign rd_fin   = rd_pend && mem_rd_done;

    assign slot_pop       = out_ack && (occ != 2'd0);
    assign slot_push      = direct || rd_fin;
    assign slot_push_data = rd_fin ? mem_rd_data : in_data;
    assign occ_n          = occ + 2'(slot_push) - 2'(slot_pop);

    assign wr_pend_n = spill || (wr_pend && !mem_wr_done);
    assign rd_pend_n = rd_pend ? !mem_rd_done
                               : ((mem_count != '0) && (occ_n != 2'd2));

    always_comb begin
        c_d = c_q;
        if (spill) c_d.wdata = in_data;
        unique case ({wr_pend_n, rd_pend_n})
            2'b11:   c_d.st = ST_WRITE_READ;
            2'b10:   c_d.st = ST_WRITE;
            2'b01:   c_d.st = ST_READ;
            default: c_d.st = (occ_n == 2'd0) ? ST_EMPTY :
                              (occ_n == 2'd1) ? ST_PART  : ST_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= ST_EMPTY;
            c_q.wdata <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_wr_req  = wr_pend;
    assign mem_rd_req  = rd_pend;
    assign mem_wr_data = c_q.wdata;
    assign wr_commit   = wr_fin;
    assign rd_commit   = rd_fin;

endmodule

// File: rtl/param_spill_cache.sv
module param_spill_cache #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ack,
    output logic          mem_wr_req,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    input  logic          mem_wr_done,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_done,
    input  logic [DW-1:0] mem_rd_data
);

    logic [1:0]    occ;
    logic [CW-1:0] mem_count;
    logic          slot_push, slot_pop;
    logic [DW-1:0] slot_push_data;
    logic          wr_commit, rd_commit;

    psc_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_ready       (in_ready),
        .out_ack        (out_ack),
        .occ            (occ),
        .mem_count      (mem_count),
        .mem_wr_done    (mem_wr_done),
        .mem_rd_done    (mem_rd_done),
        .mem_rd_data    (mem_rd_data),
        .slot_push      (slot_push),
        .slot_push_data (slot_push_data),
        .slot_pop       (slot_pop),
        .mem_wr_req     (mem_wr_req),
        .mem_wr_data    (mem_wr_data),
        .mem_rd_req     (mem_rd_req),
        .wr_commit      (wr_commit),
        .rd_commit      (rd_commit)
    );

    psc_slots #(.DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (slot_push),
        .push_data (slot_push_data),
        .pop       (slot_pop),
        .occ       (occ),
        .head_data (out_data)
    );

    psc_spill_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .wr_addr   (mem_wr_addr),
        .rd_addr   (mem_rd_addr),
        .count     (mem_count)
    );

    assign out_valid = (occ != 2'd0);

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_ack,
    input logic          mem_wr_req,
    input logic [AW-1:0] mem_wr_addr,
    input logic [DW-1:0] mem_wr_data,
    input logic          mem_wr_done,
    input logic          mem_rd_req,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic first_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (!out_valid && !mem_wr_req && !mem_rd_req && in_ready
                     && mem_wr_addr == '0 && mem_rd_addr == '0));

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_done) |=>
            (mem_wr_req && $stable(mem_wr_data) && $stable(mem_wr_addr)));

    assert_wr_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> !in_ready);

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_done) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_wr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_done) |=>
            (mem_wr_addr == (($past(mem_wr_addr) == LAST) ? '0 : $past(mem_wr_addr) + 1'b1)));

    assert_rd_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_done) |=>
            (mem_rd_addr == (($past(mem_rd_addr) == LAST) ? '0 : $past(mem_rd_addr) + 1'b1)));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

endmodule

bind param_spill_cache psc_checker #(.DW(DW), .DEPTH(DEPTH)) u_psc_checker (.*);

// File: tb/param_spill_cache_bench.sv
module param_spill_cache_bench;

    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ack;
    logic          mem_wr_req;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_wr_done;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_done;
    logic [DW-1:0] mem_rd_data;

    param_spill_cache #(.DW(DW), .DEPTH(DEPTH)) u_param_spill_cache (.*);

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] mon_exp;
    int  wr_lat = 0, rd_lat = 0, wcnt = 0, rcnt = 0;
    int  exp_wa = 0, exp_ra = 0;
    int  ack_budget = 0;
    bit  ack_rand = 1'b0, force_ack = 1'b0, seen_both = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: scoreboard pop and compare (R2)
    always @(negedge clk) begin
        if (!rst_n) begin
            out_ack = 1'b0;
        end else begin
            out_ack = force_ack;
            if (out_valid && (ack_budget > 0 || (ack_rand && $urandom_range(2) != 0))) begin
                out_ack = 1'b1;
                if (ack_budget > 0) ack_budget--;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected word", 32'(out_data), 32'd0);
                end else begin
                    mon_exp = exp_q.pop_front();
                    check(out_data == mon_exp, "R2 output order", 32'(out_data), 32'(mon_exp));
                end
            end
        end
    end

    // external memory model with programmable latency (R8 address checks)
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_wr_done = 1'b0; mem_rd_done = 1'b0; mem_rd_data = '0;
            wcnt = 0; rcnt = 0;
        end else begin
            if (mem_wr_req && mem_rd_req) seen_both = 1'b1;
            if (mem_wr_done) begin
                mem_wr_done = 1'b0; wcnt = 0;
            end else if (mem_wr_req) begin
                if (wcnt >= wr_lat) begin
                    check(int'(mem_wr_addr) == exp_wa, "R8 write address", 32'(mem_wr_addr), 32'(exp_wa));
                    model[mem_wr_addr] = mem_wr_data;
                    exp_wa = (exp_wa + 1) % DEPTH;
                    mem_wr_done = 1'b1;
                end else wcnt++;
            end
            if (mem_rd_done) begin
                mem_rd_done = 1'b0; rcnt = 0;
            end else if (mem_rd_req) begin
                if (rcnt >= rd_lat) begin
                    check(int'(mem_rd_addr) == exp_ra, "R8 read address", 32'(mem_rd_addr), 32'(exp_ra));
                    mem_rd_data = model[mem_rd_addr];
                    exp_ra = (exp_ra + 1) % DEPTH;
                    mem_rd_done = 1'b1;
                end else rcnt++;
            end
        end
    end

    // driver: offers a word, records it as expected once accepted
    task automatic send(input logic [DW-1:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        exp_q.push_back(w);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        ack_budget = 100000;
        for (int k = 0; k < 2000 && (exp_q.size() != 0 || out_valid); k++) @(negedge clk);
        repeat (2) @(negedge clk);
        ack_budget = 0;
        check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
        check(!out_valid && !mem_rd_req && !mem_wr_req, req, {29'd0, out_valid, mem_rd_req, mem_wr_req}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!out_valid, "R1 out_valid", 32'(out_valid), 32'd0);
        check(in_ready, "R1 in_ready", 32'(in_ready), 32'd1);
        check(!mem_wr_req && !mem_rd_req, "R1 requests", {30'd0, mem_wr_req, mem_rd_req}, 32'd0);
        check(mem_wr_addr == '0 && mem_rd_addr == '0, "R1 addresses", {mem_wr_addr, mem_rd_addr}, 32'd0);

        // R9: acknowledge while empty is ignored
        force_ack = 1'b1;
        repeat (2) @(negedge clk);
        force_ack = 1'b0;
        @(negedge clk);
        check(!out_valid, "R9 ack while empty", 32'(out_valid), 32'd0);

        // R3: direct capture, visible one cycle after accept
        wr_lat = 4;
        send(16'h1111);
        check(out_valid && out_data == 16'h1111, "R3 direct capture", 32'(out_data), 32'h1111);
        // R9: hold without ack
        repeat (3) @(negedge clk);
        check(out_valid && out_data == 16'h1111, "R9 head held", 32'(out_data), 32'h1111);

        // R4/R5: third word spills
        send(16'h2222);
        send(16'h3333);
        check(mem_wr_req, "R4 write request", 32'(mem_wr_req), 32'd1);
        check(mem_wr_data == 16'h3333, "R4 write data", 32'(mem_wr_data), 32'h3333);
        check(mem_wr_addr == '0, "R4 write address", 32'(mem_wr_addr), 32'd0);
        check(!in_ready, "R5 stall while writing", 32'(in_ready), 32'd0);
        check(out_data == 16'h1111, "R2 head unchanged by spill", 32'(out_data), 32'h1111);
        repeat (8) @(negedge clk);
        check(!mem_rd_req && !mem_wr_req, "R6 no read while full", {30'd0, mem_rd_req, mem_wr_req}, 32'd0);

        // R7: overlap of refill read and spill write
        rd_lat = 6; wr_lat = 1;
        ack_budget = 1;
        for (int k = 0; k < 20 && !mem_rd_req; k++) @(negedge clk);
        check(mem_rd_req && mem_rd_addr == '0, "R6 refill request", {31'd0, mem_rd_req}, 32'd1);
        send(16'h4444);
        check(mem_wr_req && mem_rd_req, "R7 both requests", {30'd0, mem_wr_req, mem_rd_req}, 32'd3);
        repeat (14) @(negedge clk);
        check(seen_both, "R7 overlap observed", 32'(seen_both), 32'd1);
        check(out_valid && out_data == 16'h2222 && !mem_rd_req, "R6 refilled and idle", 32'(out_data), 32'h2222);
        drain("R2 drain after overlap");

        // R10: memory capacity stall
        wr_lat = 0; rd_lat = 0;
        for (int i = 0; i < DEPTH + 2; i++) send(DW'(16'h5000 + i));
        repeat (4) @(negedge clk);
        check(!in_ready, "R10 memory full stall", 32'(in_ready), 32'd0);
        check(!mem_wr_req && !mem_rd_req, "R10 idle when full", {30'd0, mem_wr_req, mem_rd_req}, 32'd0);
        drain("R2 R6 drain after full memory");

        // random traffic with varying latencies
        ack_rand = 1'b1;
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                wr_lat = $urandom_range(3);
                rd_lat = $urandom_range(4);
            end
            repeat ($urandom_range(2)) @(negedge clk);
            send(DW'($urandom_range(65535)));
        end
        ack_rand = 1'b0;
        drain("R2 random traffic order");
        check(in_ready, "R5 ready after traffic", 32'(in_ready), 32'd1);

        finish_run();
    end

endmodule